// File: doc/BRIEF.md
# Write-Protection Command Sequencer

This block sits in front of a byte-addressed non-volatile array and decides which byte loads may reach it. It watches the incoming load strobe, address and data for fixed unlock codes. It keeps a protection flag. While the flag is set, a load is passed on to the array only when a short unlock code comes directly before it. A longer code either clears the flag or starts a whole-array erase.

Each accepted load gets a registered verdict one cycle later. A load that is part of a command code is never passed on. Loads that follow one another must each arrive within a byte-load window. If the window lapses, any partly entered code is dropped, and so is an open unlock.

An erase request starts an internal timer. While the timer runs, and while the array reports that it is programming, every load is ignored. A simulated power-cycle input drops any pending code or unlock. It leaves the protection flag as it was. Only the reset clears the flag.

Top module: `wp_cmd_seq`

## Requirements
- R1: After reset, prot_on, wr_permit, erase_start and erase_busy are all 0.
- R2: With protection clear, an accepted load that completes no code and matches no pending code step raises wr_permit for exactly the one cycle after the load edge.
- R3: The loads (addr 15'h5555, data 8'hAA), then (15'h2AAA, 8'h55), then (15'h5555, 8'hA0) set prot_on in the cycle after the third load. None of the three raises wr_permit.
- R4: With protection set, a load that is not preceded by the three-load unlock code leaves wr_permit at 0.
- R5: After the three-load code completes, every following load raises wr_permit, as long as each one arrives within the byte-load window of the previous load.
- R6: A gap of more than WIN_CYC clock edges between two loads ends any partial code and any open unlock. A gap of WIN_CYC edges or fewer keeps them.
- R7: A load that does not match the next expected code step returns the decoder to idle. That load is treated as an ordinary write: it is permitted if protection is clear and refused if protection is set.
- R8: The six loads AA/5555, 55/2AAA, 80/5555, AA/5555, 55/2AAA, 20/5555 clear prot_on in the cycle after the sixth load. None of the six raises wr_permit.
- R9: The same six loads with 8'h10 as the last data byte pulse erase_start for one cycle and hold erase_busy high for exactly ERASE_CYC cycles. prot_on does not change.
- R10: A load made while erase_busy or busy_in is high is ignored. It raises no wr_permit and advances no code.
- R11: A pulse on pwr_cycle keeps prot_on as it was, and drops any partial code and any open unlock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears everything, including protection |
| pwr_cycle | input | 1 | Simulated power cycle; clears the sequencing state but keeps protection |
| load_stb | input | 1 | One-cycle byte-load strobe |
| load_addr | input | 15 | Address of the load |
| load_data | input | 8 | Data of the load |
| busy_in | input | 1 | Array is programming; loads are ignored |
| prot_on | output | 1 | Protection flag |
| wr_permit | output | 1 | The previous cycle's load may be written into the array |
| erase_start | output | 1 | One-cycle pulse starting a whole-array erase |
| erase_busy | output | 1 | Erase timer running |

## Verification
The hardest case to reach from the ports is the edge of the byte-load window. A code or unlock must survive a gap of exactly WIN_CYC edges and must be dropped at one edge more. The stimulus table therefore carries an idle-gap count for each load. The bench sets these gaps to 7, 8 and 9 against a window of 8, and judges by later verdicts that a dropped code no longer completes. Ignored loads during an erase are shown by entering a full unlock code while the timer runs. After the erase, a lone final code byte and a data load must both still be refused.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

    localparam int ADDR_W = 15;
    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_LEAD,
        SQ_SECOND,
        SQ_EXT,
        SQ_EXT_LEAD,
        SQ_EXT_SECOND
    } seq_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } load_t;

    function automatic logic step_hit(load_t l, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
        return (l.addr == a) && (l.data == d);
    endfunction

endpackage

// File: rtl/wpc_window.sv
module wpc_window #(
    parameter int WIN_CYC = 15000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic restart,
    input  logic active,
    output logic expire
);
    localparam int CW = $clog2(WIN_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(WIN_CYC - 1);

    logic [CW-1:0] cnt;

    assign expire = active && !restart && !clr && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr || restart || !active) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/wpc_erase_timer.sv
module wpc_erase_timer #(
    parameter int ERASE_CYC = 2000000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic go,
    output logic busy
);
    localparam int CW = $clog2(ERASE_CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (go) begin
            busy <= 1'b1;
            cnt  <= CW'(ERASE_CYC - 1);
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/wpc_decoder.sv
module wpc_decoder
    import wpc_pkg::*;
#(
    parameter logic [ADDR_W-1:0] ADDR_A    = 15'h5555,
    parameter logic [ADDR_W-1:0] ADDR_B    = 15'h2AAA,
    parameter logic [DATA_W-1:0] D_LEAD    = 8'hAA,
    parameter logic [DATA_W-1:0] D_SECOND  = 8'h55,
    parameter logic [DATA_W-1:0] D_ENABLE  = 8'hA0,
    parameter logic [DATA_W-1:0] D_EXT     = 8'h80,
    parameter logic [DATA_W-1:0] D_DISABLE = 8'h20,
    parameter logic [DATA_W-1:0] D_ERASE   = 8'h10
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  pwr_cycle,
    input  logic  accept,
    input  load_t ld,
    input  logic  expire,
    output logic  active,
    output logic  erase_go,
    output logic  prot_on,
    output logic  wr_permit,
    output logic  erase_start
);
    seq_e seq_q, seq_n;
    logic unl_q, unl_n;
    logic prot_n, permit_n, miss;

    assign active = (seq_q != SQ_IDLE) || unl_q;

    always_comb begin
        seq_n    = seq_q;
        unl_n    = unl_q;
        prot_n   = prot_on;
        permit_n = 1'b0;
        erase_go = 1'b0;
        miss     = 1'b0;
        if (expire) begin
            seq_n = SQ_IDLE;
            unl_n = 1'b0;
        end
        if (accept) begin
            if (unl_q) begin
                permit_n = 1'b1;
            end else begin
                unique case (seq_q)
                    SQ_IDLE: begin
                        if (step_hit(ld, ADDR_A, D_LEAD)) seq_n = SQ_LEAD;
                        else miss = 1'b1;
                    end
                    SQ_LEAD: begin
                        if (step_hit(ld, ADDR_B, D_SECOND)) seq_n = SQ_SECOND;
                        else miss = 1'b1;
                    end
                    SQ_SECOND: begin
                        if (step_hit(ld, ADDR_A, D_ENABLE)) begin
                            seq_n  = SQ_IDLE;
                            prot_n = 1'b1;
                            unl_n  = 1'b1;
                        end else if (step_hit(ld, ADDR_A, D_EXT)) begin
                            seq_n = SQ_EXT;
                        end else begin
                            miss = 1'b1;
                        end
                    end
                    SQ_EXT: begin
                        if (step_hit(ld, ADDR_A, D_LEAD)) seq_n = SQ_EXT_LEAD;
                        else miss = 1'b1;
                    end
                    SQ_EXT_LEAD: begin
                        if (step_hit(ld, ADDR_B, D_SECOND)) seq_n = SQ_EXT_SECOND;
                        else miss = 1'b1;
                    end
                    SQ_EXT_SECOND: begin
                        if (step_hit(ld, ADDR_A, D_DISABLE)) begin
                            seq_n  = SQ_IDLE;
                            prot_n = 1'b0;
                        end else if (step_hit(ld, ADDR_A, D_ERASE)) begin
                            seq_n    = SQ_IDLE;
                            erase_go = 1'b1;
                        end else begin
                            miss = 1'b1;
                        end
                    end
                    default: miss = 1'b1;
                endcase
                if (miss) begin
                    seq_n    = SQ_IDLE;
                    permit_n = !prot_on;
                end
            end
        end
        if (pwr_cycle) begin
            seq_n    = SQ_IDLE;
            unl_n    = 1'b0;
            prot_n   = prot_on;
            permit_n = 1'b0;
            erase_go = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q       <= SQ_IDLE;
            unl_q       <= 1'b0;
            prot_on     <= 1'b0;
            wr_permit   <= 1'b0;
            erase_start <= 1'b0;
        end else begin
            seq_q       <= seq_n;
            unl_q       <= unl_n;
            prot_on     <= prot_n;
            wr_permit   <= permit_n;
            erase_start <= erase_go;
        end
    end
endmodule

// File: rtl/wp_cmd_seq.sv
module wp_cmd_seq
    import wpc_pkg::*;
#(
    parameter int WIN_CYC   = 15000,
    parameter int ERASE_CYC = 2000000,
    parameter logic [ADDR_W-1:0] ADDR_A    = 15'h5555,
    parameter logic [ADDR_W-1:0] ADDR_B    = 15'h2AAA,
    parameter logic [DATA_W-1:0] D_LEAD    = 8'hAA,
    parameter logic [DATA_W-1:0] D_SECOND  = 8'h55,
    parameter logic [DATA_W-1:0] D_ENABLE  = 8'hA0,
    parameter logic [DATA_W-1:0] D_EXT     = 8'h80,
    parameter logic [DATA_W-1:0] D_DISABLE = 8'h20,
    parameter logic [DATA_W-1:0] D_ERASE   = 8'h10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_cycle,
    input  logic              load_stb,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [DATA_W-1:0] load_data,
    input  logic              busy_in,
    output logic              prot_on,
    output logic              wr_permit,
    output logic              erase_start,
    output logic              erase_busy
);
    load_t ld;
    logic  accept, active, expire, erase_go;

    assign ld     = '{addr: load_addr, data: load_data};
    assign accept = load_stb && !busy_in && !erase_busy;

    wpc_window #(.WIN_CYC(WIN_CYC)) u_win (
        .clk     (clk),
        .rst     (rst),
        .clr     (pwr_cycle),
        .restart (accept),
        .active  (active),
        .expire  (expire)
    );

    wpc_decoder #(
        .ADDR_A(ADDR_A), .ADDR_B(ADDR_B), .D_LEAD(D_LEAD), .D_SECOND(D_SECOND),
        .D_ENABLE(D_ENABLE), .D_EXT(D_EXT), .D_DISABLE(D_DISABLE), .D_ERASE(D_ERASE)
    ) u_dec (
        .clk         (clk),
        .rst         (rst),
        .pwr_cycle   (pwr_cycle),
        .accept      (accept),
        .ld          (ld),
        .expire      (expire),
        .active      (active),
        .erase_go    (erase_go),
        .prot_on     (prot_on),
        .wr_permit   (wr_permit),
        .erase_start (erase_start)
    );

    wpc_erase_timer #(.ERASE_CYC(ERASE_CYC)) u_ers (
        .clk  (clk),
        .rst  (rst),
        .clr  (pwr_cycle),
        .go   (erase_go),
        .busy (erase_busy)
    );
endmodule

// File: rtl/wpc_chk.sv
module wpc_chk #(
    parameter logic [7:0] D_ENABLE = 8'hA0
) (
    input logic       clk,
    input logic       rst,
    input logic       pwr_cycle,
    input logic       load_stb,
    input logic [7:0] load_data,
    input logic       busy_in,
    input logic       prot_on,
    input logic       wr_permit,
    input logic       erase_start,
    input logic       erase_busy
);
    p_permit_from_load_r2: assert property (@(posedge clk) disable iff (rst)
        wr_permit |-> $past(load_stb && !busy_in && !erase_busy));

    p_prot_rise_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(prot_on) |-> $past(load_stb && load_data == D_ENABLE));

    p_verdicts_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_permit, erase_start}));

    p_erase_keeps_prot_r9: assert property (@(posedge clk) disable iff (rst)
        erase_start |-> erase_busy && (prot_on == $past(prot_on)));

    p_erase_ignores_r10: assert property (@(posedge clk) disable iff (rst)
        (erase_busy && load_stb) |=> !wr_permit && !erase_start);

    p_busy_ignores_r10: assert property (@(posedge clk) disable iff (rst)
        (busy_in && load_stb) |=> !wr_permit && !erase_start);

    p_pwr_keeps_prot_r11: assert property (@(posedge clk) disable iff (rst)
        pwr_cycle |=> (prot_on == $past(prot_on)) && !wr_permit);
endmodule

bind wp_cmd_seq wpc_chk #(.D_ENABLE(D_ENABLE)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pwr_cycle   (pwr_cycle),
    .load_stb    (load_stb),
    .load_data   (load_data),
    .busy_in     (busy_in),
    .prot_on     (prot_on),
    .wr_permit   (wr_permit),
    .erase_start (erase_start),
    .erase_busy  (erase_busy)
);

// File: tb/sim_wp_cmd_seq.sv
`timescale 1ns/1ps
module sim_wp_cmd_seq;
    localparam int WIN  = 8;
    localparam int ERS  = 20;
    localparam int NVEC = 25;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pwr_cycle = 1'b0;
    logic        load_stb = 1'b0;
    logic [14:0] load_addr = '0;
    logic [7:0]  load_data = '0;
    logic        busy_in = 1'b0;
    logic        prot_on, wr_permit, erase_start, erase_busy;
    int          n_cmp = 0;
    int          n_bad = 0;

    always #5 clk = ~clk;

    wp_cmd_seq #(.WIN_CYC(WIN), .ERASE_CYC(ERS)) u0 (
        .clk(clk), .rst(rst), .pwr_cycle(pwr_cycle), .load_stb(load_stb),
        .load_addr(load_addr), .load_data(load_data), .busy_in(busy_in),
        .prot_on(prot_on), .wr_permit(wr_permit), .erase_start(erase_start),
        .erase_busy(erase_busy)
    );

    // {gap[3:0], req[3:0], addr[14:0], data[7:0], exp_permit, exp_prot}
    localparam logic [32:0] TBL [0:NVEC-1] = '{
        {4'd0, 4'd2,  15'h1234, 8'h11, 1'b1, 1'b0},  // R2 plain write
        {4'd0, 4'd3,  15'h5555, 8'hAA, 1'b0, 1'b0},  // R3
        {4'd0, 4'd3,  15'h2AAA, 8'h55, 1'b0, 1'b0},  // R3
        {4'd0, 4'd3,  15'h5555, 8'hA0, 1'b0, 1'b1},  // R3 protection on
        {4'd0, 4'd5,  15'h0100, 8'h5A, 1'b1, 1'b1},  // R5 page byte
        {4'd7, 4'd6,  15'h0101, 8'h5B, 1'b1, 1'b1},  // R6 gap inside window
        {4'd8, 4'd4,  15'h0102, 8'h5C, 1'b0, 1'b1},  // R4 after unlock lapsed
        {4'd0, 4'd3,  15'h5555, 8'hAA, 1'b0, 1'b1},
        {4'd7, 4'd6,  15'h2AAA, 8'h55, 1'b0, 1'b1},  // R6 code survives gap
        {4'd0, 4'd3,  15'h5555, 8'hA0, 1'b0, 1'b1},
        {4'd0, 4'd5,  15'h0200, 8'h77, 1'b1, 1'b1},  // R5
        {4'd9, 4'd6,  15'h5555, 8'hAA, 1'b0, 1'b1},
        {4'd8, 4'd6,  15'h2AAA, 8'h55, 1'b0, 1'b1},  // R6 code dropped
        {4'd0, 4'd6,  15'h5555, 8'hA0, 1'b0, 1'b1},
        {4'd0, 4'd7,  15'h5555, 8'hAA, 1'b0, 1'b1},
        {4'd0, 4'd7,  15'h1111, 8'h55, 1'b0, 1'b1},  // R7 miss, protected
        {4'd0, 4'd8,  15'h5555, 8'hAA, 1'b0, 1'b1},  // R8
        {4'd0, 4'd8,  15'h2AAA, 8'h55, 1'b0, 1'b1},
        {4'd0, 4'd8,  15'h5555, 8'h80, 1'b0, 1'b1},
        {4'd0, 4'd8,  15'h5555, 8'hAA, 1'b0, 1'b1},
        {4'd0, 4'd8,  15'h2AAA, 8'h55, 1'b0, 1'b1},
        {4'd0, 4'd8,  15'h5555, 8'h20, 1'b0, 1'b0},  // R8 protection off
        {4'd0, 4'd2,  15'h0300, 8'h33, 1'b1, 1'b0},
        {4'd0, 4'd7,  15'h5555, 8'hAA, 1'b0, 1'b0},
        {4'd0, 4'd7,  15'h0400, 8'h44, 1'b1, 1'b0}   // R7 miss, unprotected
    };

    task automatic check(string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic do_load(int gap, logic [14:0] a, logic [7:0] d);
        repeat (gap) @(negedge clk);
        load_stb  = 1'b1;
        load_addr = a;
        load_data = d;
        @(negedge clk);
        load_stb  = 1'b0;
    endtask

    task automatic pulse_pwr();
        pwr_cycle = 1'b1;
        @(negedge clk);
        pwr_cycle = 1'b0;
    endtask

    task automatic six_code(logic [7:0] last, int gap0);
        do_load(gap0, 15'h5555, 8'hAA);
        do_load(0, 15'h2AAA, 8'h55);
        do_load(0, 15'h5555, 8'h80);
        do_load(0, 15'h5555, 8'hAA);
        do_load(0, 15'h2AAA, 8'h55);
        do_load(0, 15'h5555, last);
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog (all requirements): actual still running, expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 prot_on after reset", prot_on, 0);
        check("R1 wr_permit after reset", wr_permit, 0);
        check("R1 erase_start after reset", erase_start, 0);
        check("R1 erase_busy after reset", erase_busy, 0);

        for (int i = 0; i < NVEC; i++) begin
            logic [32:0] v;
            v = TBL[i];
            do_load(int'(v[32:29]), v[24:10], v[9:2]);
            check($sformatf("R%0d permit, vector %0d", v[28:25], i), wr_permit, v[1]);
            check($sformatf("R%0d protection, vector %0d", v[28:25], i), prot_on, v[0]);
        end

        // R10: array busy, load ignored
        busy_in = 1'b1;
        do_load(0, 15'h0600, 8'h66);
        check("R10 load during busy_in", wr_permit, 0);
        busy_in = 1'b0;

        // enable, then erase after the unlock lapses (R9)
        do_load(0, 15'h5555, 8'hAA);
        do_load(0, 15'h2AAA, 8'h55);
        do_load(0, 15'h5555, 8'hA0);
        check("R3 protection set again", prot_on, 1);
        six_code(8'h10, 9);
        check("R9 erase_start pulse", erase_start, 1);
        check("R9 erase_busy raised", erase_busy, 1);
        check("R9 protection kept over erase", prot_on, 1);
        check("R9 erase code not written", wr_permit, 0);
        begin
            int n;
            n = 1;
            @(negedge clk);
            check("R9 erase_start one cycle", erase_start, 0);
            if (erase_busy) n++;
            while (erase_busy) begin
                @(negedge clk);
                if (erase_busy) n++;
            end
            check("R9 erase_busy length", n, ERS);
        end

        // R10: loads during erase are ignored and advance no code
        six_code(8'h10, 0);
        check("R9 second erase start", erase_start, 1);
        do_load(0, 15'h5555, 8'hAA);
        check("R10 code byte during erase", wr_permit, 0);
        do_load(0, 15'h2AAA, 8'h55);
        check("R10 code byte during erase", wr_permit, 0);
        do_load(0, 15'h5555, 8'hA0);
        check("R10 code byte during erase", wr_permit, 0);
        do_load(0, 15'h0700, 8'h77);
        check("R10 data during erase", wr_permit, 0);
        check("R10 erase still running", erase_busy, 1);
        while (erase_busy) @(negedge clk);
        do_load(0, 15'h5555, 8'hA0);
        check("R10 lone final byte refused", wr_permit, 0);
        do_load(0, 15'h0701, 8'h78);
        check("R10 no unlock from ignored loads", wr_permit, 0);
        check("R9 protection after erase", prot_on, 1);

        // R11: power cycle keeps protection, drops code and unlock
        do_load(0, 15'h5555, 8'hAA);
        do_load(0, 15'h2AAA, 8'h55);
        pulse_pwr();
        check("R11 protection kept", prot_on, 1);
        do_load(0, 15'h5555, 8'hA0);
        check("R11 partial code dropped", wr_permit, 0);
        do_load(0, 15'h0800, 8'h88);
        check("R11 no unlock after dropped code", wr_permit, 0);
        do_load(0, 15'h5555, 8'hAA);
        do_load(0, 15'h2AAA, 8'h55);
        do_load(0, 15'h5555, 8'hA0);
        pulse_pwr();
        check("R11 protection kept after unlock", prot_on, 1);
        do_load(0, 15'h0801, 8'h89);
        check("R11 unlock dropped", wr_permit, 0);

        // R1: reset clears protection
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset clears protection", prot_on, 0);
        do_load(0, 15'h0900, 8'h99);
        check("R2 write after reset", wr_permit, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule